// File: doc/BRIEF.md
# Packed Subword Integer ALU

This block is a subword-parallel integer datapath. It takes two operand words and applies one operation to every lane of them in the same cycle. The lane width is chosen per operation from 8, 16, 32 or 64 bits. Carries, borrows, comparisons and shifts stop at the lane edge, so a 64-bit operand acts as eight, four, two or one independent numbers. The available operations are:

- add and subtract, either wrapping or saturating (signed or unsigned);
- the four bitwise operations;
- per-lane equality and signed greater-than masks;
- logical and arithmetic shifts by a common count;
- a multiply-accumulate that pairs 16-bit lanes into 32-bit sums.

A caller presents the opcode, lane width, saturation mode and both operands together with `in_valid`. The result appears on `result` one clock later, marked by `out_valid`. When `in_valid` is low, the output register keeps its previous value. The operand register file and any movement of data to or from memory belong to the surrounding datapath.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals `in_valid` from the previous clock edge. `result` is loaded only on an edge where `in_valid` is 1 and otherwise holds its value.
- R3: `lane_sel` selects the lane width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. With `sat_mode` 0 or 3, opcode 0 (add) and opcode 1 (subtract, A minus B) give each lane's result modulo 2^width, with no carry into the next lane.
- R4: With `sat_mode` 1, add and subtract clamp each lane to the signed range [-2^(w-1), 2^(w-1)-1].
- R5: With `sat_mode` 2, add and subtract clamp each lane to the unsigned range [0, 2^w-1].
- R6: Opcodes 2, 3, 4 and 5 give A AND B, A OR B, A XOR B and (NOT A) AND B across the whole word, whatever the values of `lane_sel` and `sat_mode`.
- R7: Opcode 6 fills a lane with all ones when the A and B lanes are equal. Opcode 7 does the same when the A lane is greater than the B lane as signed numbers. In every other case the lane is all zeros.
- R8: Opcodes 8, 9 and 10 shift every A lane left logically, right logically, or right arithmetically. The count is the full B operand read as an unsigned number, and every lane uses the same count. When the count is at least the lane width, the logical shifts give 0 and the arithmetic shift fills the lane with its sign bit.
- R9: Opcode 11 splits each 32-bit group into two signed 16-bit halves. It forms A_lo·B_lo + A_hi·B_hi modulo 2^32 for the group. `lane_sel` and `sat_mode` are ignored. For example, all four inputs of -32768 give 0x80000000.
- R10: Opcodes 12 to 15 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The inputs hold an operation this cycle |
| opcode | input | 4 | Operation code (see R3 to R10) |
| lane_sel | input | 2 | Lane width select (see R3) |
| sat_mode | input | 2 | Overflow handling for add and subtract |
| opa | input | DATA_W | Operand A |
| opb | input | DATA_W | Operand B, which is also the shift count |
| out_valid | output | 1 | `result` holds a new value |
| result | output | DATA_W | Registered result |

## Verification
The properties assume that every control input has a known value on each sampled edge, and that the whole opcode range can occur, because opcodes 12 to 15 are defined. The bench drives inputs only at the falling edge, so that assumption holds at every rising edge. It keeps `in_valid` low for the whole reset interval, and it sweeps every opcode, lane width and saturation mode with corner operands and pseudo-random operands. Some properties hold only when the two operands are identical, and the directed corner pairs include the equal-operand cases those properties need.

// File: rtl/simd_alu_pkg.sv
`timescale 1ns/1ps
package simd_alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_AND   = 4'd2,
      OP_OR    = 4'd3,
      OP_XOR   = 4'd4,
      OP_ANDN  = 4'd5,
      OP_CMPEQ = 4'd6,
      OP_CMPGT = 4'd7,
      OP_SLL   = 4'd8,
      OP_SRL   = 4'd9,
      OP_SRA   = 4'd10,
      OP_MADD  = 4'd11
   } simd_op_e;

   localparam logic [1:0] SAT_WRAP   = 2'd0;
   localparam logic [1:0] SAT_SIGNED = 2'd1;
   localparam logic [1:0] SAT_UNSIGN = 2'd2;

   localparam int LANE_KINDS = 4;   // 8, 16, 32, 64-bit lanes
   localparam int BASE_LANE  = 8;
   localparam int CNT_BITS   = 6;   // shift count bits that can be in range
endpackage

// File: rtl/simd_addsub.sv
`timescale 1ns/1ps
module simd_addsub #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic [1:0]        sat_mode,
   output logic [DATA_W-1:0] y
);
   import simd_alu_pkg::*;
   localparam int NLANE = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_cfg
      $error("simd_addsub: DATA_W must be a multiple of LANE_W");
   end

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      logic [LANE_W-1:0] la, lb, wrap_v, sgn_v, uns_v;
      logic [LANE_W:0]   u_res, s_res;
      logic              s_ovf;

      assign la    = a[i*LANE_W +: LANE_W];
      assign lb    = b[i*LANE_W +: LANE_W];
      assign u_res = sub ? ({1'b0, la} - {1'b0, lb}) : ({1'b0, la} + {1'b0, lb});
      assign s_res = sub ? ({la[LANE_W-1], la} - {lb[LANE_W-1], lb})
                         : ({la[LANE_W-1], la} + {lb[LANE_W-1], lb});
      assign s_ovf = s_res[LANE_W] ^ s_res[LANE_W-1];

      assign wrap_v = u_res[LANE_W-1:0];
      assign sgn_v  = !s_ovf ? s_res[LANE_W-1:0]
                    : (s_res[LANE_W] ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}});
      assign uns_v  = !u_res[LANE_W] ? u_res[LANE_W-1:0]
                    : (sub ? {LANE_W{1'b0}} : {LANE_W{1'b1}});

      always_comb begin
         case (sat_mode)
            SAT_SIGNED: y[i*LANE_W +: LANE_W] = sgn_v;
            SAT_UNSIGN: y[i*LANE_W +: LANE_W] = uns_v;
            default:    y[i*LANE_W +: LANE_W] = wrap_v;
         endcase
      end
   end
endmodule

// File: rtl/simd_cmp.sv
`timescale 1ns/1ps
module simd_cmp #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] eq_mask,
   output logic [DATA_W-1:0] gt_mask
);
   localparam int NLANE = DATA_W / LANE_W;

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      logic signed [LANE_W-1:0] sa, sb;
      assign sa = a[i*LANE_W +: LANE_W];
      assign sb = b[i*LANE_W +: LANE_W];
      assign eq_mask[i*LANE_W +: LANE_W] = {LANE_W{sa == sb}};
      assign gt_mask[i*LANE_W +: LANE_W] = {LANE_W{sa > sb}};
   end
endmodule

// File: rtl/simd_shift.sv
`timescale 1ns/1ps
module simd_shift #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [5:0]        amt,
   input  logic              big,
   output logic [DATA_W-1:0] sll_v,
   output logic [DATA_W-1:0] srl_v,
   output logic [DATA_W-1:0] sra_v
);
   localparam int NLANE = DATA_W / LANE_W;
   localparam logic [6:0] LW7 = 7'(LANE_W);

   if (LANE_W > 64) begin : g_bad_cfg
      $error("simd_shift: lanes wider than 64 bits are not supported");
   end

   logic over;
   assign over = big || ({1'b0, amt} >= LW7);

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      logic [LANE_W-1:0] la, ar;
      assign la = a[i*LANE_W +: LANE_W];
      assign ar = $signed(la) >>> amt;
      assign sll_v[i*LANE_W +: LANE_W] = over ? '0 : (la << amt);
      assign srl_v[i*LANE_W +: LANE_W] = over ? '0 : (la >> amt);
      assign sra_v[i*LANE_W +: LANE_W] = over ? {LANE_W{la[LANE_W-1]}} : ar;
   end
endmodule

// File: rtl/simd_madd.sv
`timescale 1ns/1ps
module simd_madd #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   localparam int HALF   = 16;
   localparam int GROUP  = 2 * HALF;
   localparam int NGROUP = DATA_W / GROUP;

   for (genvar g = 0; g < NGROUP; g++) begin : g_grp
      logic signed [GROUP-1:0] p_lo, p_hi;
      assign p_lo = $signed(a[g*GROUP +: HALF]) * $signed(b[g*GROUP +: HALF]);
      assign p_hi = $signed(a[g*GROUP+HALF +: HALF]) * $signed(b[g*GROUP+HALF +: HALF]);
      assign y[g*GROUP +: GROUP] = p_lo + p_hi;
   end
endmodule

// File: rtl/simd_alu.sv
`timescale 1ns/1ps
module simd_alu #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        opcode,
   input  logic [1:0]        lane_sel,
   input  logic [1:0]        sat_mode,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   import simd_alu_pkg::*;

   if (DATA_W % 64 != 0 || DATA_W < 64) begin : g_bad_cfg
      $error("simd_alu: DATA_W must be a positive multiple of 64");
   end

   logic [DATA_W-1:0] add_v [LANE_KINDS];
   logic [DATA_W-1:0] sub_v [LANE_KINDS];
   logic [DATA_W-1:0] eq_v  [LANE_KINDS];
   logic [DATA_W-1:0] gt_v  [LANE_KINDS];
   logic [DATA_W-1:0] sll_v [LANE_KINDS];
   logic [DATA_W-1:0] srl_v [LANE_KINDS];
   logic [DATA_W-1:0] sra_v [LANE_KINDS];
   logic [DATA_W-1:0] madd_v;
   logic              cnt_big;

   assign cnt_big = |opb[DATA_W-1:CNT_BITS];

   for (genvar k = 0; k < LANE_KINDS; k++) begin : g_size
      localparam int LW = BASE_LANE << k;

      simd_addsub #(.DATA_W(DATA_W), .LANE_W(LW)) u_add (
         .a(opa), .b(opb), .sub(1'b0), .sat_mode(sat_mode), .y(add_v[k]));
      simd_addsub #(.DATA_W(DATA_W), .LANE_W(LW)) u_sub (
         .a(opa), .b(opb), .sub(1'b1), .sat_mode(sat_mode), .y(sub_v[k]));
      simd_cmp #(.DATA_W(DATA_W), .LANE_W(LW)) u_cmp (
         .a(opa), .b(opb), .eq_mask(eq_v[k]), .gt_mask(gt_v[k]));
      simd_shift #(.DATA_W(DATA_W), .LANE_W(LW)) u_shf (
         .a(opa), .amt(opb[CNT_BITS-1:0]), .big(cnt_big),
         .sll_v(sll_v[k]), .srl_v(srl_v[k]), .sra_v(sra_v[k]));
   end

   simd_madd #(.DATA_W(DATA_W)) u_madd (.a(opa), .b(opb), .y(madd_v));

   logic [DATA_W-1:0] next_res;
   always_comb begin
      case (opcode)
         OP_ADD:   next_res = add_v[lane_sel];
         OP_SUB:   next_res = sub_v[lane_sel];
         OP_AND:   next_res = opa & opb;
         OP_OR:    next_res = opa | opb;
         OP_XOR:   next_res = opa ^ opb;
         OP_ANDN:  next_res = ~opa & opb;
         OP_CMPEQ: next_res = eq_v[lane_sel];
         OP_CMPGT: next_res = gt_v[lane_sel];
         OP_SLL:   next_res = sll_v[lane_sel];
         OP_SRL:   next_res = srl_v[lane_sel];
         OP_SRA:   next_res = sra_v[lane_sel];
         OP_MADD:  next_res = madd_v;
         default:  next_res = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end
endmodule

// File: rtl/simd_alu_chk.sv
`timescale 1ns/1ps
module simd_alu_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        opcode,
   input logic [1:0]        lane_sel,
   input logic [1:0]        sat_mode,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && result == '0));

   p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result)));

   p_sub_self_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 4'd1 && opa == opb) |=> result == '0);

   p_and_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 4'd2) |=> result == ($past(opa) & $past(opb)));

   p_eq_self_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 4'd6 && opa == opb) |=> result == '1);

   p_gt_self_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 4'd7 && opa == opb) |=> result == '0);

   p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode >= 4'd12) |=> result == '0);
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
   .lane_sel(lane_sel), .sat_mode(sat_mode), .opa(opa), .opb(opb),
   .out_valid(out_valid), .result(result));

// File: tb/simd_alu_test.sv
`timescale 1ns/1ps
module simd_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  opcode = '0;
   logic [1:0]  lane_sel = '0;
   logic [1:0]  sat_mode = '0;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic        out_valid;
   logic [63:0] result;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   simd_alu #(.DATA_W(64)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .lane_sel(lane_sel), .sat_mode(sat_mode), .opa(opa), .opb(opb),
      .out_valid(out_valid), .result(result));

   function automatic logic [63:0] model(int op, int ls, int sm,
                                         logic [63:0] a, logic [63:0] b);
      int w, n;
      logic [63:0] mask, x, z, y, r;
      logic signed [65:0] sa, sb, t, hi, lo;
      logic signed [63:0] s;
      w = 8 << ls;
      n = 64 / w;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      r = '0;
      if (op == 11) begin
         for (int k = 0; k < 2; k++) begin
            s = 64'($signed(a[32*k +: 16])) * 64'($signed(b[32*k +: 16]))
              + 64'($signed(a[32*k+16 +: 16])) * 64'($signed(b[32*k+16 +: 16]));
            r[32*k +: 32] = s[31:0];
         end
         return r;
      end
      if (op == 2) return a & b;
      if (op == 3) return a | b;
      if (op == 4) return a ^ b;
      if (op == 5) return ~a & b;
      if (op >= 12) return '0;
      for (int i = 0; i < n; i++) begin
         x = (a >> (i*w)) & mask;
         z = (b >> (i*w)) & mask;
         sa = $signed({2'b00, x});
         sb = $signed({2'b00, z});
         if (x[w-1]) sa = sa - (66'sd1 <<< w);
         if (z[w-1]) sb = sb - (66'sd1 <<< w);
         y = '0;
         case (op)
            0, 1: begin
               if (sm == 1) begin
                  t  = (op == 0) ? sa + sb : sa - sb;
                  hi = (66'sd1 <<< (w-1)) - 66'sd1;
                  lo = -(66'sd1 <<< (w-1));
                  if (t > hi) t = hi;
                  if (t < lo) t = lo;
                  y = t[63:0] & mask;
               end else begin
                  t = (op == 0) ? $signed({2'b00, x}) + $signed({2'b00, z})
                                : $signed({2'b00, x}) - $signed({2'b00, z});
                  if (sm == 2 && t < 0) y = '0;
                  else if (sm == 2 && t > $signed({2'b00, mask})) y = mask;
                  else y = t[63:0] & mask;
               end
            end
            6: y = (x == z) ? mask : '0;
            7: y = (sa > sb) ? mask : '0;
            8: y = (b >= 64'(w)) ? '0 : ((x << b[6:0]) & mask);
            9: y = (b >= 64'(w)) ? '0 : (x >> b[6:0]);
            10: begin
               if (b >= 64'(w)) y = (sa < 0) ? mask : '0;
               else begin
                  t = sa >>> b[6:0];
                  y = t[63:0] & mask;
               end
            end
            default: y = '0;
         endcase
         r = r | ((y & mask) << (i*w));
      end
      return r;
   endfunction

   function automatic string req_of(int op, int sm);
      if (op <= 1) return (sm == 1) ? "R4" : (sm == 2) ? "R5" : "R3";
      if (op <= 5) return "R6";
      if (op <= 7) return "R7";
      if (op <= 10) return "R8";
      if (op == 11) return "R9";
      return "R10";
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one operation at a falling edge and check it at the next one.
   task automatic run_vec(int op, int ls, int sm, logic [63:0] a, logic [63:0] b);
      logic [63:0] exp;
      exp = model(op, ls, sm, a, b);
      in_valid = 1'b1;
      opcode   = 4'(op);
      lane_sel = 2'(ls);
      sat_mode = 2'(sm);
      opa      = a;
      opb      = b;
      @(negedge clk);
      check("R2", {63'd0, out_valid}, 64'd1);
      check(req_of(op, sm), result, exp);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   logic [63:0] corners [12];
   initial begin
      corners[0]  = 64'h0000_0000_0000_0000;
      corners[1]  = 64'hFFFF_FFFF_FFFF_FFFF;
      corners[2]  = 64'h8000_0000_0000_0000;
      corners[3]  = 64'h7F7F_7F7F_7F7F_7F7F;
      corners[4]  = 64'h8080_8080_8080_8080;
      corners[5]  = 64'h0101_0101_0101_0101;
      corners[6]  = 64'hFFFF_0000_FFFF_0000;
      corners[7]  = 64'h8000_7FFF_0001_FFFF;
      corners[8]  = 64'h0000_0000_0000_0001;
      corners[9]  = 64'h0000_0000_0000_0007;
      corners[10] = 64'h0000_0000_0000_0010;
      corners[11] = 64'h0000_0000_0000_003F;
   end

   initial begin
      #(20 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [63:0] lfsr, ra, rb, last;
      lfsr = 64'h1234_5678_9ABC_DEF1;
      // R1: reset state, with in_valid low throughout reset
      repeat (3) @(negedge clk);
      check("R1", {63'd0, out_valid}, 64'd0);
      check("R1", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {63'd0, out_valid}, 64'd0);
      check("R1", result, 64'd0);

      // R9 corner: all four inputs -32768 wrap to 0x80000000 per group
      run_vec(11, 2, 1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
      check("R9", result, 64'h8000_0000_8000_0000);

      // Sweep every opcode, lane width and saturation mode
      for (int op = 0; op < 16; op++) begin
         for (int ls = 0; ls < 4; ls++) begin
            for (int sm = 0; sm < 4; sm++) begin
               for (int ia = 0; ia < 12; ia++) begin
                  for (int ib = 0; ib < 12; ib++) begin
                     run_vec(op, ls, sm, corners[ia], corners[ib]);
                  end
               end
               for (int k = 0; k < 8; k++) begin
                  lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
                  ra = lfsr;
                  lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
                  rb = (op >= 8 && op <= 10) ? {58'd0, lfsr[5:0]} : lfsr;
                  run_vec(op, ls, sm, ra, rb);
               end
            end
         end
      end

      // R2: with in_valid low the output holds while the inputs change
      run_vec(0, 0, 0, 64'h0102_0304_0506_0708, 64'h1111_1111_1111_1111);
      last = result;
      in_valid = 1'b0;
      opcode   = 4'd4;
      opa      = 64'hDEAD_BEEF_0000_FFFF;
      opb      = 64'h1234_1234_1234_1234;
      @(negedge clk);
      check("R2", {63'd0, out_valid}, 64'd0);
      check("R2", result, last);
      @(negedge clk);
      check("R2", result, 64'h1213_1415_1617_1819);

      finish_run();
   end
endmodule